// File: doc/BRIEF.md
# Programmable Pattern Generator Sequencer

This block produces a stream of 16-bit words, one per clock, from a small stored program. Every program slot pairs an output word with a control code. A slot can simply pass on to the next slot. It can also ramp its word upward for a number of extra clocks, or name another slot to run next. A few slots are enough to describe a long counter ramp, or a short loop that repeats without end, such as a walking-ones pattern.

Software or a test controller fills the program through a write port. Each write carries a slot address, a word, a code and an operand. A pulse on the start input then launches execution from slot 0. From one clock after the start pulse, a valid word appears on every clock. A new start pulse at any time throws away the current position and any ramp in progress, and begins again at slot 0.

Top module: `patseq_top`

## Requirements
- R1: While reset is asserted, and afterwards until the first start pulse, `pat_vld` is 0. Reset also drives `pat_word` to 0.
- R2: A start pulse sampled at a clock edge restarts execution at slot 0 with no ramp in progress. The word of slot 0 is valid one clock after that edge. A start during a ramp abandons the ramp.
- R3: A slot whose code is 2'b00 (plain), or the spare code 2'b11, emits its word for one clock. Execution then moves to slot address + 1.
- R4: A slot with code 2'b01 (ramp) and operand n emits its word, then word+1, and so on up to word+n, modulo 2^16. That is n+1 clocks in all, during which the slot address is held. Execution then moves to slot address + 1.
- R5: A ramp slot with operand 0 behaves exactly like a plain slot.
- R6: A slot with code 2'b10 (jump) emits its own word for one clock. The next clock then executes the slot named by its operand, and execution continues sequentially from there.
- R7: A jump operand wider than the slot address is reduced modulo the program depth (256 slots). Operand 0x3C8 therefore selects slot 200.
- R8: Sequential advance past the last slot (255) wraps to slot 0.
- R9: Once started, `pat_vld` stays 1 on every clock until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Generator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin or restart execution at slot 0 |
| prog_we | input | 1 | Write one program slot on this clock |
| prog_addr | input | 8 | Slot address for the write |
| prog_word | input | 16 | Output word stored in the slot |
| prog_code | input | 2 | Control code: 00 plain, 01 ramp, 10 jump, 11 plain |
| prog_arg | input | 10 | Ramp length or jump target |
| pat_word | output | 16 | Generated word |
| pat_vld | output | 1 | `pat_word` carries a generated value |

## Verification
The hardest case to reach is a restart that lands in the middle of a ramp. The slot address and the ramp step must both return to zero while the output register still shows the word that was in flight. The bench loads a ten-step ramp and lets four steps go out. It then pulses start and checks the word captured on that same edge. After that it checks the full ramp again from its base. A second hard case is the wrap of a jump operand wider than the slot address. The bench reaches it by closing the walking-ones loop with an operand whose upper bits are set. It then runs the loop several times.

// File: rtl/patseq_pkg.sv
package patseq_pkg;
    typedef enum logic [1:0] {
        OP_PLAIN = 2'b00,
        OP_RAMP  = 2'b01,
        OP_JUMP  = 2'b10,
        OP_SPARE = 2'b11
    } op_e;
endpackage

// File: rtl/patseq_mem.sv
module patseq_mem
    import patseq_pkg::*;
#(
    parameter int AW  = 8,
    parameter int DW  = 16,
    parameter int OPW = 10
) (
    input  logic           clk,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_word,
    input  op_e            wr_op,
    input  logic [OPW-1:0] wr_arg,
    input  logic [AW-1:0]  rd_addr,
    output logic [DW-1:0]  rd_word,
    output op_e            rd_op,
    output logic [OPW-1:0] rd_arg
);
    localparam int DEPTH = 1 << AW;
    localparam int EW    = DW + 2 + OPW;

    logic [EW-1:0] slots_q [DEPTH];
    logic [EW-1:0] rd_ent;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots_q[wr_addr] <= {wr_word, wr_op, wr_arg};
        end
    end

    always_comb begin
        rd_ent  = slots_q[rd_addr];
        rd_word = rd_ent[EW-1 -: DW];
        rd_op   = op_e'(rd_ent[OPW +: 2]);
        rd_arg  = rd_ent[OPW-1:0];
    end
endmodule

// File: rtl/patseq_core.sv
module patseq_core
    import patseq_pkg::*;
#(
    parameter int AW  = 8,
    parameter int DW  = 16,
    parameter int OPW = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [DW-1:0]  ent_word_i,
    input  op_e            ent_op_i,
    input  logic [OPW-1:0] ent_arg_i,
    output logic [AW-1:0]  pc_o,
    output logic [DW-1:0]  word_o,
    output logic           vld_o
);
    typedef struct packed {
        logic           run;
        logic [AW-1:0]  pc;
        logic [OPW-1:0] step;
        logic [DW-1:0]  word;
        logic           vld;
    } seq_t;

    seq_t st_d, st_q;
    logic [DW-1:0] emit_d;
    logic [AW-1:0] jump_tgt;

    always_comb begin
        st_d     = st_q;
        jump_tgt = ent_arg_i[AW-1:0];
        emit_d   = ent_word_i;
        if (ent_op_i == OP_RAMP) begin
            emit_d = ent_word_i + DW'(st_q.step);
        end
        st_d.vld = st_q.run;
        if (st_q.run) begin
            st_d.word = emit_d;
            unique case (ent_op_i)
                OP_RAMP: begin
                    if (st_q.step == ent_arg_i) begin
                        st_d.step = '0;
                        st_d.pc   = st_q.pc + 1'b1;
                    end else begin
                        st_d.step = st_q.step + 1'b1;
                    end
                end
                OP_JUMP: begin
                    st_d.step = '0;
                    st_d.pc   = jump_tgt;
                end
                default: begin
                    st_d.step = '0;
                    st_d.pc   = st_q.pc + 1'b1;
                end
            endcase
        end
        if (start_i) begin
            st_d.run  = 1'b1;
            st_d.pc   = '0;
            st_d.step = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o   = st_q.pc;
    assign word_o = st_q.word;
    assign vld_o  = st_q.vld;

    AST_IDLE_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |=> !vld_o); // R1
    AST_START_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (st_q.pc == '0 && st_q.step == '0)); // R2
    AST_RAMP_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !start_i && ent_op_i == OP_RAMP && st_q.step != ent_arg_i)
        |=> ($stable(st_q.pc) && st_q.step == $past(st_q.step) + 1'b1)); // R4
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !start_i && ent_op_i == OP_JUMP)
        |=> st_q.pc == $past(ent_arg_i[AW-1:0])); // R6
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |=> (st_q.run && vld_o)); // R9
endmodule

// File: rtl/patseq_top.sv
module patseq_top
    import patseq_pkg::*;
#(
    parameter int AW  = 8,
    parameter int DW  = 16,
    parameter int OPW = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           prog_we,
    input  logic [AW-1:0]  prog_addr,
    input  logic [DW-1:0]  prog_word,
    input  logic [1:0]     prog_code,
    input  logic [OPW-1:0] prog_arg,
    output logic [DW-1:0]  pat_word,
    output logic           pat_vld
);
    logic [AW-1:0]  pc;
    logic [DW-1:0]  ent_word;
    op_e            ent_op;
    logic [OPW-1:0] ent_arg;

    patseq_mem #(.AW(AW), .DW(DW), .OPW(OPW)) u_mem (
        .clk     (clk),
        .wr_en   (prog_we),
        .wr_addr (prog_addr),
        .wr_word (prog_word),
        .wr_op   (op_e'(prog_code)),
        .wr_arg  (prog_arg),
        .rd_addr (pc),
        .rd_word (ent_word),
        .rd_op   (ent_op),
        .rd_arg  (ent_arg)
    );

    patseq_core #(.AW(AW), .DW(DW), .OPW(OPW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .ent_word_i (ent_word),
        .ent_op_i   (ent_op),
        .ent_arg_i  (ent_arg),
        .pc_o       (pc),
        .word_o     (pat_word),
        .vld_o      (pat_vld)
    );
endmodule

// File: tb/sim_patseq_top.sv
`timescale 1ns/1ps
module sim_patseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        prog_we = 1'b0;
    logic [7:0]  prog_addr = '0;
    logic [15:0] prog_word = '0;
    logic [1:0]  prog_code = '0;
    logic [9:0]  prog_arg = '0;
    logic [15:0] pat_word;
    logic        pat_vld;

    int n_cmp = 0;
    int n_bad = 0;

    logic [15:0] m_word [256];
    logic [1:0]  m_code [256];
    logic [9:0]  m_arg  [256];
    int  mpc = 0;
    int  mstep = 0;
    bit  mrun = 0;

    always #2.5 clk = ~clk;

    patseq_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .prog_we(prog_we),
        .prog_addr(prog_addr), .prog_word(prog_word), .prog_code(prog_code),
        .prog_arg(prog_arg), .pat_word(pat_word), .pat_vld(pat_vld)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_word();
        if (m_code[mpc] == 2'b01) return m_word[mpc] + 16'(mstep);
        return m_word[mpc];
    endfunction

    task automatic adv();
        case (m_code[mpc])
            2'b01: if (mstep == int'(m_arg[mpc])) begin mstep = 0; mpc = (mpc + 1) % 256; end
                   else mstep++;
            2'b10: begin mstep = 0; mpc = int'(m_arg[mpc]) % 256; end
            default: begin mstep = 0; mpc = (mpc + 1) % 256; end
        endcase
    endtask

    // All tasks start and end right after a falling edge.
    task automatic ld(input int a, input logic [15:0] w, input logic [1:0] c, input logic [9:0] g);
        prog_we = 1'b1; prog_addr = 8'(a); prog_word = w; prog_code = c; prog_arg = g;
        m_word[a] = w; m_code[a] = c; m_arg[a] = g;
        @(posedge clk); @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset vld", 16'(pat_vld), 16'h0);
        check("R1 reset word", pat_word, 16'h0);
        rst_n = 1'b1;
        mrun = 0;
        for (int i = 0; i < 2; i++) begin
            @(posedge clk); @(negedge clk);
            check("R1 idle vld", 16'(pat_vld), 16'h0);
        end
    endtask

    task automatic kick(input string req);
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        if (mrun) begin
            check(req, pat_word, exp_word());
        end else begin
            check("R1 vld low on start edge", 16'(pat_vld), 16'h0);
        end
        mpc = 0; mstep = 0; mrun = 1;
    endtask

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            check("R9 vld held", 16'(pat_vld), 16'h1);
            check(req, pat_word, exp_word());
            adv();
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        for (int a = 0; a < 256; a++) ld(a, 16'h0, 2'b00, 10'h0);
        do_reset();

        // R4 / R6: 256-value ramp then jump back
        ld(0, 16'h0000, 2'b01, 10'd255);
        ld(1, 16'h00FF, 2'b10, 10'd0);
        do_reset();
        kick("R2");
        run(2 * 257, "R4 ramp 0..255 loop");

        // R6 / R7 / R3: jump 0 -> 200, walking ones, closing jump wraps 0x3C8 -> 200
        ld(0,   16'h0000, 2'b10, 10'd200);
        ld(200, 16'h0000, 2'b00, 10'd0);
        ld(201, 16'h1111, 2'b00, 10'd0);
        ld(202, 16'h2222, 2'b00, 10'd0);
        ld(203, 16'h4444, 2'b00, 10'd0);
        ld(204, 16'h8888, 2'b00, 10'd0);
        ld(205, 16'hFFFF, 2'b10, 10'h3C8);
        do_reset();
        kick("R2");
        run(1 + 6 * 3, "R7 walking-ones loop with wrapped target");

        // R4 / R5 sweep of ramp lengths 0..8
        for (int n = 0; n <= 8; n++) begin
            ld(0, 16'(16 * n), 2'b01, 10'(n));
            ld(1, 16'hBEEF, 2'b10, 10'd0);
            do_reset();
            kick("R2");
            run(2 * (n + 2) + 1, (n == 0) ? "R5 ramp zero" : "R4 ramp sweep");
        end

        // R4 data wrap, R3 spare code as plain
        ld(0, 16'hFFFE, 2'b01, 10'd3);
        ld(1, 16'h5555, 2'b11, 10'd7);
        ld(2, 16'h7777, 2'b10, 10'd0);
        do_reset();
        kick("R2");
        run(15, "R4 ramp wraps / R3 spare code");

        // R8: slot 255 advances to slot 0
        ld(0,   16'h1234, 2'b10, 10'd255);
        ld(255, 16'hABCD, 2'b00, 10'd0);
        do_reset();
        kick("R2");
        run(9, "R8 wrap past last slot");

        // R2: restart in the middle of a ramp
        ld(0, 16'h0100, 2'b01, 10'd9);
        ld(1, 16'h0AAA, 2'b10, 10'd0);
        do_reset();
        kick("R2");
        run(4, "R4 ramp before restart");
        kick("R2 word captured on restart edge");
        run(12, "R2 ramp restarts from base");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule